// File: doc/BRIEF.md
# Hamming Single-Bit Sector Corrector

This block checks one 512-byte sector after it has been read into a local byte-wide buffer. It takes two 24-bit Hamming codes: the one computed while the sector streamed in and the one kept in the spare area. Their bitwise difference (the syndrome) classifies the sector.

An all-zero syndrome means the data is clean. A syndrome with exactly twelve ones marks a single flipped data bit. The block decodes the byte and bit position from the odd-numbered syndrome bits and repairs that bit in the buffer with one read and one write. Any other syndrome is reported as uncorrectable, and the buffer is left alone.

A single-cycle start strobe launches a job. A one-cycle done pulse returns the result. The status code stays valid until the next job finishes. The buffer port has a one-cycle synchronous read latency.

Top module: `ecc_hamming_fix`

## Requirements
- R1: The syndrome is the bitwise XOR of calc_code_i and spare_code_i. Code byte 0 is bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16. Only the XOR matters, not the absolute code values.
- R2: A zero syndrome gives status 2'b00 (clean) and makes no buffer read or write.
- R3: A syndrome with exactly 12 set bits gives status 2'b01 (corrected) after exactly one buffer read and one buffer write.
- R4: Any other nonzero syndrome gives status 2'b10 (uncorrectable) and makes no buffer read or write. Status 2'b11 never appears.
- R5: The corrected bit index is syndrome bits {5,3,1}, with bit 1 as the LSB.
- R6: The corrected byte address is syndrome bits {23,21,19,17,15,13,11,9,7}, with bit 7 as the LSB, giving 0 to 511.
- R7: The write goes to the address just read and carries the read byte XOR (1 << bit index). No other byte changes.
- R8: Timing is counted in rising edges from the edge that samples start_i. For a clean or uncorrectable result, done_o is high after the second edge. For a correctable result, mem_rd_o is high after the second edge, mem_wr_o after the third, and done_o after the fourth. done_o lasts one cycle.
- R9: A start_i pulse that arrives while a job is in progress is ignored. It produces no extra done_o pulse and no buffer access.
- R10: After reset, done_o, mem_rd_o and mem_wr_o are low and status_o is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a check; sampled only while idle |
| calc_code_i | input | 24 | Code computed over the sector data |
| spare_code_i | input | 24 | Code read from the spare area |
| mem_addr_o | output | 9 | Sector buffer byte address |
| mem_rd_o | output | 1 | Buffer read request; data returns one cycle later |
| mem_rdata_i | input | 8 | Buffer read data |
| mem_wr_o | output | 1 | Buffer write strobe |
| mem_wdata_o | output | 8 | Buffer write data |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
The hardest outcome to reach from the ports is a repair at the extreme buffer addresses and bit positions. The twelve-ones condition constrains every syndrome bit at once, so arbitrary code pairs almost never hit it. The stimulus builds each syndrome on purpose: the wanted byte and bit go into the odd positions and their complement into the even positions, which makes the population exactly twelve. This is done for byte 0 bit 0, byte 511 bit 7 and an interior position, each over different base codes. Near-miss populations of 11 and 13 ones, and a start pulse injected in the middle of a repair, probe the edges of the classification and of the sequencing.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_BAD   = 2'b10
  } hc_status_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_EVAL  = 2'b01,
    PH_READ  = 2'b10,
    PH_WRITE = 2'b11
  } hc_phase_e;
endpackage

// File: rtl/hc_syndrome.sv
module hc_syndrome #(
  parameter int BIT_W  = 3,
  parameter int BYTE_W = 9,
  localparam int CODE_W = 2 * (BIT_W + BYTE_W),
  localparam int CNT_W  = $clog2(CODE_W + 1)
) (
  input  logic [CODE_W-1:0] syn_i,
  output logic              zero_o,
  output logic              single_o,
  output logic [BYTE_W-1:0] byte_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o
);
  localparam int ONES_SINGLE = BIT_W + BYTE_W;

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < CODE_W; i++) begin
      ones = ones + CNT_W'(syn_i[i]);
    end
  end

  assign zero_o   = (syn_i == '0);
  assign single_o = (ones == CNT_W'(ONES_SINGLE));

  // odd syndrome positions carry the location, low part first
  for (genvar b = 0; b < BIT_W; b++) begin : g_bit
    assign bit_idx_o[b] = syn_i[2*b + 1];
  end
  for (genvar y = 0; y < BYTE_W; y++) begin : g_byte
    assign byte_idx_o[y] = syn_i[2*(BIT_W + y) + 1];
  end
endmodule

// File: rtl/hc_rmw_ctrl.sv
module hc_rmw_ctrl
  import hc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       zero_i,
  input  logic       single_i,
  output logic       idle_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic       done_o,
  output logic [1:0] status_o
);
  hc_phase_e  phase_q, phase_d;
  logic       done_q, done_d;
  hc_status_e stat_q, stat_d;

  always_comb begin
    phase_d = phase_q;
    done_d  = 1'b0;
    stat_d  = stat_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_EVAL;
      PH_EVAL: begin
        if (zero_i) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
          stat_d  = ST_CLEAN;
        end else if (single_i) begin
          phase_d = PH_READ;
        end else begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
          stat_d  = ST_BAD;
        end
      end
      PH_READ:  phase_d = PH_WRITE;
      PH_WRITE: begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
        stat_d  = ST_FIXED;
      end
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      stat_q  <= ST_CLEAN;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      stat_q  <= stat_d;
    end
  end

  assign idle_o   = (phase_q == PH_IDLE);
  assign rd_o     = (phase_q == PH_READ);
  assign wr_o     = (phase_q == PH_WRITE);
  assign done_o   = done_q;
  assign status_o = stat_q;
endmodule

// File: rtl/ecc_hamming_fix.sv
module ecc_hamming_fix #(
  parameter int BIT_W  = 3,
  parameter int BYTE_W = 9,
  localparam int CODE_W = 2 * (BIT_W + BYTE_W),
  localparam int DATA_W = 1 << BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] calc_code_i,
  input  logic [CODE_W-1:0] spare_code_i,
  output logic [BYTE_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  logic [CODE_W-1:0] syn_q, syn_d;
  logic              syn_en;
  logic              idle, zero, single;
  logic [BIT_W-1:0]  bit_idx;

  assign syn_en = start_i & idle;
  assign syn_d  = calc_code_i ^ spare_code_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syn_q <= '0;
    else if (syn_en) syn_q <= syn_d;
  end

  hc_syndrome #(.BIT_W(BIT_W), .BYTE_W(BYTE_W)) u_syn (
    .syn_i      (syn_q),
    .zero_o     (zero),
    .single_o   (single),
    .byte_idx_o (mem_addr_o),
    .bit_idx_o  (bit_idx)
  );

  hc_rmw_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .zero_i   (zero),
    .single_i (single),
    .idle_o   (idle),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .done_o   (done_o),
    .status_o (status_o)
  );

  assign mem_wdata_o = mem_rdata_i ^ (DATA_W'(1) << bit_idx);
endmodule

// File: rtl/hc_chk.sv
module hc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] mem_addr_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       done_o,
  input logic [1:0] status_o
);
  // R7
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> $past(mem_rd_o) && $stable(mem_addr_o));
  // R8
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> mem_wr_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R3
  fixed_wrote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 2'b01) |-> $past(mem_wr_o));
  // R2
  no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != 2'b01) |-> !$past(mem_rd_o) && !$past(mem_wr_o));
  // R4
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'b11);
  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));
endmodule

bind ecc_hamming_fix hc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .done_o     (done_o),
  .status_o   (status_o)
);

// File: tb/ecc_hamming_fix_tb.sv
module ecc_hamming_fix_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] calc = '0, spare = '0;
  logic [8:0]  addr;
  logic        rd, wr, done;
  logic [7:0]  rdata = '0, wdata;
  logic [1:0]  status;

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [8:0] last_wa = '0;
  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];

  always #4 clk = ~clk;

  ecc_hamming_fix u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .calc_code_i(calc), .spare_code_i(spare),
    .mem_addr_o(addr), .mem_rd_o(rd), .mem_rdata_i(rdata),
    .mem_wr_o(wr), .mem_wdata_o(wdata),
    .done_o(done), .status_o(status)
  );

  always @(posedge clk) begin
    if (rd) begin rdata <= mem[addr]; rd_cnt <= rd_cnt + 1; end
    if (wr) begin mem[addr] <= wdata; wr_cnt <= wr_cnt + 1; last_wa <= addr; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_syn(input int b, input int k);
    logic [11:0] v;
    logic [23:0] s;
    v = {b[8:0], k[2:0]};
    for (int i = 0; i < 12; i++) begin
      s[2*i+1] = v[i];
      s[2*i]   = ~v[i];
    end
    return s;
  endfunction

  task automatic run_job(input logic [23:0] c, input logic [23:0] s,
                         input logic [1:0] exp_st, input int exp_lat, input string tag);
    int rd0, wr0, n;
    bit diff;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk); calc = c; spare = s; start = 1'b1;
    @(negedge clk); start = 1'b0; n = 1;
    while (!done && n < 20) begin @(negedge clk); n++; end
    check(n == exp_lat, {tag, " R8 latency"}, n, exp_lat);
    check(status == exp_st, {tag, " status"}, status, exp_st);
    @(negedge clk);
    check(!done, {tag, " R8 pulse width"}, done, 0);
    check(rd_cnt - rd0 == (exp_st == 2'b01 ? 1 : 0), {tag, " reads"}, rd_cnt - rd0, 0);
    check(wr_cnt - wr0 == (exp_st == 2'b01 ? 1 : 0), {tag, " writes"}, wr_cnt - wr0, 0);
    diff = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) diff = 1;
    check(!diff, {tag, " R7 buffer contents"}, diff, 0);
  endtask

  task automatic t_fix(input logic [23:0] base, input int b, input int k, input string tag);
    exp_mem[b] = exp_mem[b] ^ (8'd1 << k);
    run_job(base, base ^ mk_syn(b, k), 2'b01, 4, tag);
    check(last_wa == 9'(b), {tag, " R6 byte address"}, last_wa, b);
    check(mem[b] == exp_mem[b], {tag, " R5 bit flip"}, mem[b], exp_mem[b]);
  endtask

  task automatic t_busy();
    int n;
    exp_mem[77] = exp_mem[77] ^ 8'h08;
    @(negedge clk); calc = 24'h123456; spare = 24'h123456 ^ mk_syn(77, 3); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); calc = 24'h0; spare = 24'h000001; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done) n++;
    end
    check(n == 1, "R9 done count", n, 1);
    check(status == 2'b01, "R9 status kept", status, 1);
    check(mem[77] == exp_mem[77], "R9 buffer", mem[77], exp_mem[77]);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 37 + 11);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!done && !rd && !wr, "R10 strobes low", {done, rd, wr}, 0);
    check(status == 2'b00, "R10 status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !rd && !wr && status == 2'b00, "R10 after release", status, 0);

    run_job(24'hA5C3F0, 24'hA5C3F0, 2'b00, 2, "R2 clean");
    run_job(24'h000000, 24'h000000, 2'b00, 2, "R2 clean zero");
    t_fix(24'h000000, 0, 0, "R3 byte0 bit0");
    t_fix(24'hFFFFFF, 511, 7, "R3 byte511 bit7");
    t_fix(24'h5A3C96, 298, 5, "R1 interior");
    t_fix(24'h0F0F0F, 298, 5, "R1 same syndrome other base");
    run_job(24'h000000, 24'h000001, 2'b10, 2, "R4 one bit");
    run_job(24'h00FF00, 24'hFF00FF, 2'b10, 2, "R4 all ones");
    run_job(24'h0007FF, 24'h000000, 2'b10, 2, "R4 eleven ones");
    run_job(24'h111111, 24'h111111 ^ 24'h001FFF, 2'b10, 2, "R4 thirteen ones");
    t_busy();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule